// File: doc/BRIEF.md
# USB OUT Endpoint Receive Buffer

This block holds the data that a host sends to one non-control OUT endpoint of a USB device. The link side delivers each packet as a start pulse, a run of data-valid bytes and an end pulse that carries the CRC verdict. The block writes good packets into an on-chip byte RAM and answers every packet with an accept, a NAK or an overrun indication. It discards packets that are corrupt, too long, or arrive while no buffer is free.

Software drains the stored data through a byte-read port. It sees one ready flag per buffer and the length of the last accepted packet. A buffer goes back to the link either through a clear strobe or, when auto-release is selected, as soon as its last byte has been read. Storage is set in 64-byte units. It can be split into two alternating buffers, and for bulk traffic it can pack several full-size packets into one buffer.

Top module: `ep_rx_buffer`

## Requirements
- R1: After reset the endpoint behaves as a bulk endpoint with one buffer of 64 bytes, a 64-byte packet limit and the continuous and auto-release modes off. buf_rdy is 0, rd_empty is 1, wr_count is 0, cfg_err is 0 and no response is pulsed.
- R2: Buffer capacity is cfg_units × 64 bytes. A value of 0 acts as 1 and a value above 16 acts as 16. A packet that would not fit in the space left in the buffer is discarded.
- R3: One cycle after the end pulse of a good packet that has a free buffer, resp_ack pulses and wr_count holds the packet's byte count. Outside continuous mode, the filled buffer's buf_rdy bit sets one cycle later.
- R4: A packet that arrives while the buffer being filled is still ready is discarded. cfg_type encodes 0 bulk, 1 interrupt, 2 isochronous and 3 (which acts like bulk). A bulk or interrupt endpoint answers with a one-cycle resp_nak. An isochronous endpoint answers with a one-cycle resp_ovr and never with resp_nak.
- R5: A packet whose end pulse has rx_crc_ok low, or that holds more bytes than cfg_maxp, is discarded without any response. The bytes of the next accepted packet land where the discarded ones would have gone.
- R6: With cfg_dbl set there are two buffers: buf_rdy bit 0 for the first and bit 1 for the second. The link fills them alternately starting with buffer 0, and the read port drains them in the same order.
- R7: rd_data shows the next unread byte of the oldest ready buffer in arrival order, and rd_en advances to the following byte. rd_empty is 1 when that buffer has been fully read or no buffer is ready, and rd_en then has no effect.
- R8: With auto-release off, clr_strobe releases the oldest ready buffer, even if bytes remain unread. clr_strobe is ignored when no buffer is ready or when auto-release is on.
- R9: With auto-release on, the oldest ready buffer is released one cycle after its last byte has been read, in both single and continuous modes.
- R10: In continuous mode (bulk only), accepted packets of exactly cfg_maxp bytes are appended to the same buffer. The buffer becomes ready when it is full or when a shorter packet is accepted. Every accepted packet still pulses resp_ack.
- R11: cfg_err is 1 when continuous mode is requested for a bulk endpoint whose capacity is not a whole multiple of cfg_maxp, and continuous mode is then ignored. A continuous request for any other transfer type is ignored without an error.
- R12: cfg_load captures all configuration inputs and empties both buffers, so buf_rdy reads 0 on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_load | input | 1 | Capture configuration and flush buffers |
| cfg_type | input | 2 | Transfer type: 0 bulk, 1 interrupt, 2 isochronous |
| cfg_units | input | 5 | Buffer capacity in 64-byte units |
| cfg_maxp | input | 11 | Maximum packet size in bytes |
| cfg_dbl | input | 1 | Two alternating buffers |
| cfg_cont | input | 1 | Continuous receive request |
| cfg_autoclr | input | 1 | Auto-release after full read |
| rx_start | input | 1 | Packet start pulse |
| rx_valid | input | 1 | Data byte strobe |
| rx_data | input | 8 | Data byte |
| rx_end | input | 1 | Packet end pulse |
| rx_crc_ok | input | 1 | CRC verdict, valid with rx_end |
| resp_ack | output | 1 | Packet accepted |
| resp_nak | output | 1 | Packet refused, buffer busy |
| resp_ovr | output | 1 | Isochronous overrun |
| rd_en | input | 1 | Advance read pointer |
| rd_data | output | 8 | Current read byte |
| rd_empty | output | 1 | No unread byte available |
| clr_strobe | input | 1 | Manual buffer release |
| buf_rdy | output | 2 | Per-buffer ready flags |
| wr_count | output | 11 | Byte count of the last accepted packet |
| cfg_err | output | 1 | Continuous mode configuration error |

## Verification
The bench targets a bad-CRC packet placed between good ones, and a packet one byte over the limit. A design that failed to rewind its write pointer would then return shifted or stale bytes on the read port. It drives a packet into a busy buffer for each transfer type, where swapping the NAK and overrun answers or accepting the data would show at the response pins. Continuous mode is exercised with full-size runs, a short tail and a capacity that is not a multiple of the packet size. A design that completed too early, too late or with a wrong length would show the ready flag at the wrong time or the wrong number of bytes. Auto-release and manual clear are mixed in double-buffer mode to catch a release of the wrong buffer or a clear that should have been ignored.

// File: rtl/ep_rx_pkg.sv
package ep_rx_pkg;

  typedef enum logic [1:0] {
    XFER_BULK = 2'd0,
    XFER_INT  = 2'd1,
    XFER_ISO  = 2'd2,
    XFER_RSVD = 2'd3
  } xfer_e;

  // Number of storage units actually used for a requested count.
  function automatic int unsigned units_used(int unsigned req, int unsigned max_units);
    if (req == 0) return 1;
    if (req > max_units) return max_units;
    return req;
  endfunction

  // True when whole packets of maxp bytes tile the buffer exactly.
  function automatic logic tiles_exactly(int unsigned cap, int unsigned maxp);
    return (maxp != 0) && ((cap % maxp) == 0);
  endfunction

endpackage

// File: rtl/ep_rx_cfg.sv
module ep_rx_cfg
  import ep_rx_pkg::*;
#(
  parameter int UNIT_BYTES = 64,
  parameter int MAX_UNITS  = 16,
  parameter int OFF_W      = 11,
  parameter int UW         = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [1:0]       in_type,
  input  logic [UW-1:0]    in_units,
  input  logic [OFF_W-1:0] in_maxp,
  input  logic             in_dbl,
  input  logic             in_cont,
  input  logic             in_auto,
  output xfer_e            type_q,
  output logic [OFF_W-1:0] size_q,
  output logic [OFF_W-1:0] maxp_q,
  output logic             dbl_q,
  output logic             auto_q,
  output logic             cont_eff,
  output logic             cont_err
);

  logic cont_q;
  logic want_cont;
  logic fits;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      type_q <= XFER_BULK;
      size_q <= OFF_W'(UNIT_BYTES);
      maxp_q <= OFF_W'(UNIT_BYTES);
      dbl_q  <= 1'b0;
      auto_q <= 1'b0;
      cont_q <= 1'b0;
    end else if (load) begin
      type_q <= xfer_e'(in_type);
      size_q <= OFF_W'(units_used(32'(in_units), MAX_UNITS) * UNIT_BYTES);
      maxp_q <= in_maxp;
      dbl_q  <= in_dbl;
      auto_q <= in_auto;
      cont_q <= in_cont;
    end
  end

  assign want_cont = cont_q && (type_q == XFER_BULK);
  assign fits      = tiles_exactly(32'(size_q), 32'(maxp_q));
  assign cont_eff  = want_cont && fits;
  assign cont_err  = want_cont && !fits;

endmodule

// File: rtl/ep_rx_fill.sv
module ep_rx_fill
  import ep_rx_pkg::*;
#(
  parameter int AW    = 10,
  parameter int OFF_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             rx_start,
  input  logic             rx_valid,
  input  logic [7:0]       rx_data,
  input  logic             rx_end,
  input  logic             rx_crc_ok,
  input  xfer_e            type_q,
  input  logic [OFF_W-1:0] size_q,
  input  logic [OFF_W-1:0] maxp_q,
  input  logic             dbl_q,
  input  logic             cont_eff,
  input  logic [1:0]       rdy,
  output logic             mem_we,
  output logic [AW:0]      mem_waddr,
  output logic [7:0]       mem_wdata,
  output logic [1:0]       set_rdy,
  output logic [OFF_W-1:0] set_len,
  output logic             resp_ack,
  output logic             resp_nak,
  output logic             resp_ovr,
  output logic [OFF_W-1:0] wr_count
);

  logic             widx, in_pkt, drop, bad;
  logic [OFF_W-1:0] fill_ptr, base_ptr, pkt_cnt;
  logic             room, take, finish;

  assign room      = (pkt_cnt < maxp_q) && (fill_ptr < size_q);
  assign take      = in_pkt && rx_valid && !drop && !bad;
  assign mem_we    = take && room;
  assign mem_waddr = {widx, fill_ptr[AW-1:0]};
  assign mem_wdata = rx_data;
  assign finish    = !cont_eff || (pkt_cnt < maxp_q) || (fill_ptr == size_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      widx <= 1'b0; in_pkt <= 1'b0; drop <= 1'b0; bad <= 1'b0;
      fill_ptr <= '0; base_ptr <= '0; pkt_cnt <= '0;
      set_rdy <= '0; set_len <= '0; wr_count <= '0;
      resp_ack <= 1'b0; resp_nak <= 1'b0; resp_ovr <= 1'b0;
    end else begin
      resp_ack <= 1'b0;
      resp_nak <= 1'b0;
      resp_ovr <= 1'b0;
      set_rdy  <= '0;
      if (flush) begin
        widx <= 1'b0; in_pkt <= 1'b0; fill_ptr <= '0; base_ptr <= '0;
      end else if (rx_start) begin
        in_pkt   <= 1'b1;
        pkt_cnt  <= '0;
        drop     <= rdy[widx];
        bad      <= 1'b0;
        fill_ptr <= base_ptr;
      end else if (in_pkt && rx_valid) begin
        if (mem_we) begin
          fill_ptr <= fill_ptr + OFF_W'(1);
          pkt_cnt  <= pkt_cnt + OFF_W'(1);
        end
        if (take && !room) bad <= 1'b1;
      end else if (in_pkt && rx_end) begin
        in_pkt <= 1'b0;
        if (drop) begin
          resp_ovr <= (type_q == XFER_ISO);
          resp_nak <= (type_q != XFER_ISO);
        end else if (bad || !rx_crc_ok) begin
          fill_ptr <= base_ptr;
        end else begin
          resp_ack <= 1'b1;
          wr_count <= pkt_cnt;
          if (finish) begin
            set_rdy[widx] <= 1'b1;
            set_len       <= fill_ptr;
            fill_ptr      <= '0;
            base_ptr      <= '0;
            widx          <= dbl_q ? ~widx : 1'b0;
          end else begin
            base_ptr <= fill_ptr;
          end
        end
      end
    end
  end

endmodule

// File: rtl/ep_rx_drain.sv
module ep_rx_drain #(
  parameter int AW    = 10,
  parameter int OFF_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             rd_en,
  input  logic             clr_strobe,
  input  logic             auto_q,
  input  logic             dbl_q,
  input  logic [1:0]       set_rdy,
  input  logic [OFF_W-1:0] set_len,
  output logic [1:0]       rdy,
  output logic [AW:0]      mem_raddr,
  output logic             rd_empty,
  output logic             pop,
  output logic             rel_evt
);

  logic [OFF_W-1:0] len_q [2];
  logic [OFF_W-1:0] rptr;
  logic             ridx;
  logic             cur_rdy, drained;

  assign cur_rdy   = rdy[ridx];
  assign drained   = (rptr == len_q[ridx]);
  assign rd_empty  = !cur_rdy || drained;
  assign pop       = rd_en && !rd_empty;
  assign rel_evt   = cur_rdy && (auto_q ? drained : clr_strobe);
  assign mem_raddr = {ridx, rptr[AW-1:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy  <= '0;
      rptr <= '0;
      ridx <= 1'b0;
      for (int i = 0; i < 2; i++) len_q[i] <= '0;
    end else if (flush) begin
      rdy  <= '0;
      rptr <= '0;
      ridx <= 1'b0;
    end else begin
      for (int i = 0; i < 2; i++) begin
        if (set_rdy[i]) begin
          rdy[i]   <= 1'b1;
          len_q[i] <= set_len;
        end
      end
      if (rel_evt) begin
        rdy[ridx] <= 1'b0;
        rptr      <= '0;
        ridx      <= dbl_q ? ~ridx : 1'b0;
      end else if (pop) begin
        rptr <= rptr + OFF_W'(1);
      end
    end
  end

endmodule

// File: rtl/ep_rx_ram.sv
module ep_rx_ram #(
  parameter int AW = 10
) (
  input  logic        clk,
  input  logic        we,
  input  logic [AW:0] waddr,
  input  logic [7:0]  wdata,
  input  logic [AW:0] raddr,
  output logic [7:0]  rdata
);

  localparam int DEPTH = 2 ** (AW + 1);

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/ep_rx_buffer.sv
module ep_rx_buffer
  import ep_rx_pkg::*;
#(
  parameter  int UNIT_BYTES = 64,
  parameter  int MAX_UNITS  = 16,
  localparam int MAX_BYTES  = UNIT_BYTES * MAX_UNITS,
  localparam int AW         = $clog2(MAX_BYTES),
  localparam int OFF_W      = AW + 1,
  localparam int UW         = $clog2(MAX_UNITS) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_load,
  input  logic [1:0]       cfg_type,
  input  logic [UW-1:0]    cfg_units,
  input  logic [OFF_W-1:0] cfg_maxp,
  input  logic             cfg_dbl,
  input  logic             cfg_cont,
  input  logic             cfg_autoclr,
  input  logic             rx_start,
  input  logic             rx_valid,
  input  logic [7:0]       rx_data,
  input  logic             rx_end,
  input  logic             rx_crc_ok,
  output logic             resp_ack,
  output logic             resp_nak,
  output logic             resp_ovr,
  input  logic             rd_en,
  output logic [7:0]       rd_data,
  output logic             rd_empty,
  input  logic             clr_strobe,
  output logic [1:0]       buf_rdy,
  output logic [OFF_W-1:0] wr_count,
  output logic             cfg_err
);

  xfer_e            type_q;
  logic [OFF_W-1:0] size_q, maxp_q, set_len;
  logic             dbl_q, auto_q, cont_eff;
  logic             mem_we, pop, rel_evt;
  logic [AW:0]      mem_waddr, mem_raddr;
  logic [7:0]       mem_wdata;
  logic [1:0]       set_rdy;

  ep_rx_cfg #(.UNIT_BYTES(UNIT_BYTES), .MAX_UNITS(MAX_UNITS), .OFF_W(OFF_W), .UW(UW)) u_cfg (
    .clk(clk), .rst_n(rst_n), .load(cfg_load), .in_type(cfg_type), .in_units(cfg_units),
    .in_maxp(cfg_maxp), .in_dbl(cfg_dbl), .in_cont(cfg_cont), .in_auto(cfg_autoclr),
    .type_q(type_q), .size_q(size_q), .maxp_q(maxp_q), .dbl_q(dbl_q), .auto_q(auto_q),
    .cont_eff(cont_eff), .cont_err(cfg_err)
  );

  ep_rx_fill #(.AW(AW), .OFF_W(OFF_W)) u_fill (
    .clk(clk), .rst_n(rst_n), .flush(cfg_load), .rx_start(rx_start), .rx_valid(rx_valid),
    .rx_data(rx_data), .rx_end(rx_end), .rx_crc_ok(rx_crc_ok), .type_q(type_q),
    .size_q(size_q), .maxp_q(maxp_q), .dbl_q(dbl_q), .cont_eff(cont_eff), .rdy(buf_rdy),
    .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata), .set_rdy(set_rdy),
    .set_len(set_len), .resp_ack(resp_ack), .resp_nak(resp_nak), .resp_ovr(resp_ovr),
    .wr_count(wr_count)
  );

  ep_rx_drain #(.AW(AW), .OFF_W(OFF_W)) u_drain (
    .clk(clk), .rst_n(rst_n), .flush(cfg_load), .rd_en(rd_en), .clr_strobe(clr_strobe),
    .auto_q(auto_q), .dbl_q(dbl_q), .set_rdy(set_rdy), .set_len(set_len), .rdy(buf_rdy),
    .mem_raddr(mem_raddr), .rd_empty(rd_empty), .pop(pop), .rel_evt(rel_evt)
  );

  ep_rx_ram #(.AW(AW)) u_ram (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .raddr(mem_raddr), .rdata(rd_data)
  );

endmodule

// File: rtl/ep_rx_chk.sv
module ep_rx_chk #(
  parameter int OFF_W = 11
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rx_end,
  input logic             resp_ack,
  input logic             resp_nak,
  input logic             resp_ovr,
  input logic [1:0]       buf_rdy,
  input logic             rd_empty,
  input logic [OFF_W-1:0] wr_count,
  input logic             cfg_err,
  input logic             cont_eff,
  input logic [1:0]       type_q
);

  // R4
  resp_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({resp_ack, resp_nak, resp_ovr}));

  // R3
  resp_follows_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_ack || resp_nak || resp_ovr) |-> $past(rx_end));

  // R4
  ovr_iso_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_ovr |-> ($past(type_q) == 2'd2));

  // R4
  nak_not_iso_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_nak |-> ($past(type_q) != 2'd2));

  // R3
  count_on_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(wr_count) |-> resp_ack);

  // R6
  rdy0_after_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(buf_rdy[0]) |-> $past(rx_end, 2));

  // R6
  rdy1_after_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(buf_rdy[1]) |-> $past(rx_end, 2));

  // R7
  empty_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_rdy == 2'b00) |-> rd_empty);

  // R11
  err_blocks_cont_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> !cont_eff);

endmodule

bind ep_rx_buffer ep_rx_chk #(.OFF_W(OFF_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .rx_end(rx_end), .resp_ack(resp_ack), .resp_nak(resp_nak),
  .resp_ovr(resp_ovr), .buf_rdy(buf_rdy), .rd_empty(rd_empty), .wr_count(wr_count),
  .cfg_err(cfg_err), .cont_eff(cont_eff), .type_q(type_q)
);

// File: tb/test_ep_rx_buffer.sv
module test_ep_rx_buffer;

  localparam int OFF_W = 11;
  localparam int UW    = 5;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             cfg_load = 1'b0, cfg_dbl = 1'b0, cfg_cont = 1'b0, cfg_autoclr = 1'b0;
  logic [1:0]       cfg_type = 2'd0;
  logic [UW-1:0]    cfg_units = '0;
  logic [OFF_W-1:0] cfg_maxp = '0;
  logic             rx_start = 1'b0, rx_valid = 1'b0, rx_end = 1'b0, rx_crc_ok = 1'b0;
  logic [7:0]       rx_data = '0;
  logic             resp_ack, resp_nak, resp_ovr;
  logic             rd_en = 1'b0, clr_strobe = 1'b0;
  logic [7:0]       rd_data;
  logic             rd_empty;
  logic [1:0]       buf_rdy;
  logic [OFF_W-1:0] wr_count;
  logic             cfg_err;

  ep_rx_buffer i_ep_rx_buffer (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_type(cfg_type), .cfg_units(cfg_units),
    .cfg_maxp(cfg_maxp), .cfg_dbl(cfg_dbl), .cfg_cont(cfg_cont), .cfg_autoclr(cfg_autoclr),
    .rx_start(rx_start), .rx_valid(rx_valid), .rx_data(rx_data), .rx_end(rx_end),
    .rx_crc_ok(rx_crc_ok), .resp_ack(resp_ack), .resp_nak(resp_nak), .resp_ovr(resp_ovr),
    .rd_en(rd_en), .rd_data(rd_data), .rd_empty(rd_empty), .clr_strobe(clr_strobe),
    .buf_rdy(buf_rdy), .wr_count(wr_count), .cfg_err(cfg_err)
  );

  always #5 clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;

  // Reference model state
  int         m_type = 0, m_size = 64, m_maxp = 64;
  bit         m_dbl = 0, m_cont = 0, m_auto = 0;
  logic [7:0] mbuf [2][1024];
  int         mlen [2];
  int         mrp [2];
  bit         mrdy [2];
  int         widx = 0, ridx = 0, mfn = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int cap_of(int units);
    int u = units;
    if (u < 1) u = 1;
    if (u > 16) u = 16;
    return u * 64;
  endfunction

  function automatic int rdy_vec();
    return (mrdy[1] ? 2 : 0) + (mrdy[0] ? 1 : 0);
  endfunction

  task automatic m_release();
    mrdy[ridx] = 0;
    mrp[ridx]  = 0;
    ridx       = m_dbl ? (ridx ^ 1) : 0;
  endtask

  task automatic do_cfg(input int t, input int units, input int maxp,
                        input bit dbl, input bit cont, input bit au);
    bit want, fits;
    cfg_type = 2'(t); cfg_units = UW'(units); cfg_maxp = OFF_W'(maxp);
    cfg_dbl = dbl; cfg_cont = cont; cfg_autoclr = au; cfg_load = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0;
    m_type = t; m_size = cap_of(units); m_maxp = maxp; m_dbl = dbl; m_auto = au;
    want   = cont && (t == 0);
    fits   = (maxp != 0) && (m_size % maxp == 0);
    m_cont = want && fits;
    mrdy[0] = 0; mrdy[1] = 0; mrp[0] = 0; mrp[1] = 0;
    widx = 0; ridx = 0; mfn = 0;
    chk(cfg_err == (want && !fits), "R11 cfg_err", int'(cfg_err), int'(want && !fits));
    chk(buf_rdy == 2'b00, "R12 flush", int'(buf_rdy), 0);
  endtask

  task automatic send(input int n, input bit crc);
    logic [7:0] pkt [1100];
    bit busy, bad, fin;
    int exp_r;
    string tag;
    busy = mrdy[widx];
    bad  = !crc || (n > m_maxp) || (mfn + n > m_size);
    for (int i = 0; i < n; i++) pkt[i] = 8'($urandom);
    rx_start = 1'b1;
    @(negedge clk);
    rx_start = 1'b0;
    for (int i = 0; i < n; i++) begin
      rx_valid = 1'b1; rx_data = pkt[i];
      @(negedge clk);
    end
    rx_valid = 1'b0; rx_end = 1'b1; rx_crc_ok = crc;
    @(negedge clk);
    rx_end = 1'b0;
    if (busy)      begin exp_r = (m_type == 2) ? 1 : 2; tag = "R4 busy response"; end
    else if (bad)  begin exp_r = 0; tag = "R5 discard silent"; end
    else           begin exp_r = 4; tag = m_cont ? "R10 cont ack" : "R3 ack"; end
    chk({resp_ack, resp_nak, resp_ovr} == 3'(exp_r), tag,
        int'({resp_ack, resp_nak, resp_ovr}), exp_r);
    if (!busy && !bad) begin
      chk(wr_count == OFF_W'(n), "R3 wr_count", int'(wr_count), n);
      for (int i = 0; i < n; i++) mbuf[widx][mfn + i] = pkt[i];
      mfn = mfn + n;
      fin = !m_cont || (n < m_maxp) || (mfn == m_size);
      if (fin) begin
        mlen[widx] = mfn; mrdy[widx] = 1; mrp[widx] = 0; mfn = 0;
        widx = m_dbl ? (widx ^ 1) : 0;
      end
    end
    @(negedge clk);
    chk(buf_rdy == 2'(rdy_vec()), m_cont ? "R10 ready" : "R6 ready flags",
        int'(buf_rdy), rdy_vec());
  endtask

  task automatic step(input bit r, input bit c);
    bit avail, pend_auto, pend_clr;
    avail     = mrdy[ridx] && (mrp[ridx] < mlen[ridx]);
    pend_auto = m_auto && mrdy[ridx] && !avail;
    pend_clr  = !m_auto && c && mrdy[ridx];
    if (r) begin
      if (avail) begin
        chk(!rd_empty, "R7 not empty", int'(rd_empty), 0);
        chk(rd_data == mbuf[ridx][mrp[ridx]], "R7 byte order",
            int'(rd_data), int'(mbuf[ridx][mrp[ridx]]));
      end else begin
        chk(rd_empty, "R7 empty", int'(rd_empty), 1);
      end
    end
    rd_en = r; clr_strobe = c;
    @(negedge clk);
    rd_en = 1'b0; clr_strobe = 1'b0;
    if (pend_auto || pend_clr) m_release();
    else if (r && avail) mrp[ridx]++;
    chk(buf_rdy == 2'(rdy_vec()), pend_auto ? "R9 auto release" : (c ? "R8 clear" : "R7 flags"),
        int'(buf_rdy), rdy_vec());
  endtask

  task automatic rd(input int k);
    for (int j = 0; j < k; j++) step(1'b1, 1'b0);
    step(1'b0, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog (all requirements): actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20417));
    mrdy[0] = 0; mrdy[1] = 0; mrp[0] = 0; mrp[1] = 0; mlen[0] = 0; mlen[1] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(buf_rdy == 2'b00, "R1 buf_rdy", int'(buf_rdy), 0);
    chk(rd_empty, "R1 rd_empty", int'(rd_empty), 1);
    chk(wr_count == '0, "R1 wr_count", int'(wr_count), 0);
    chk(!cfg_err, "R1 cfg_err", int'(cfg_err), 0);
    chk({resp_ack, resp_nak, resp_ovr} == 3'b000, "R1 no response",
        int'({resp_ack, resp_nak, resp_ovr}), 0);
    // R1 default bulk, one 64-byte buffer
    send(64, 1'b1);
    send(10, 1'b1);
    rd(70);
    step(1'b0, 1'b1);
    step(1'b0, 1'b1);

    // R2 capacity clamping
    do_cfg(0, 0, 1024, 0, 0, 0);
    send(65, 1'b1);
    send(64, 1'b1);
    rd(64); step(1'b0, 1'b1);
    do_cfg(0, 31, 1024, 0, 0, 0);
    send(1024, 1'b1);
    rd(1024); step(1'b0, 1'b1);

    // R5 discards, R6 alternation, R8 clear with unread data
    do_cfg(0, 2, 100, 1, 0, 0);
    send(40, 1'b0);
    send(101, 1'b1);
    send(50, 1'b1);
    send(30, 1'b1);
    send(5, 1'b1);
    chk(buf_rdy == 2'b11, "R6 both ready", int'(buf_rdy), 3);
    rd(20); step(1'b0, 1'b1);
    rd(31); step(1'b0, 1'b1);
    send(0, 1'b1);
    chk(rd_empty, "R7 zero-length empty", int'(rd_empty), 1);
    step(1'b0, 1'b1);

    // R4 isochronous overrun and interrupt NAK
    do_cfg(2, 1, 64, 0, 0, 0);
    send(64, 1'b1);
    send(8, 1'b1);
    do_cfg(1, 1, 64, 0, 0, 0);
    send(64, 1'b1);
    send(3, 1'b1);

    // R10 continuous packing
    do_cfg(0, 2, 64, 0, 1, 0);
    send(64, 1'b1);
    send(64, 1'b1);
    rd(128); step(1'b0, 1'b1);
    send(64, 1'b1);
    send(10, 1'b1);
    rd(80); step(1'b0, 1'b1);
    send(64, 1'b1);
    send(64, 1'b0);
    send(64, 1'b1);
    rd(128); step(1'b0, 1'b1);

    // R11 configuration error and ignored requests
    do_cfg(0, 3, 128, 0, 1, 0);
    send(128, 1'b1);
    do_cfg(2, 3, 128, 0, 1, 0);
    do_cfg(1, 2, 64, 0, 1, 0);
    send(64, 1'b1);

    // R9 auto release, R8 clear ignored under auto release
    do_cfg(0, 1, 64, 1, 0, 1);
    send(20, 1'b1);
    send(30, 1'b1);
    rd(25);
    step(1'b0, 1'b1);
    rd(30);

    // Random phase
    for (int r = 0; r < 8; r++) begin
      int t, mp, sel;
      t  = int'($urandom % 3);
      mp = (($urandom % 4) + 1) * 16 + ((($urandom % 2) == 1) ? 20 : 0);
      do_cfg(t, int'($urandom % 5), mp, 1'($urandom), 1'($urandom), 1'($urandom));
      for (int op = 0; op < 40; op++) begin
        sel = int'($urandom % 5);
        if (sel < 2) begin
          int n;
          n = int'($urandom % (m_maxp + 1));
          if ((($urandom % 4) == 0) && (m_maxp >= 16)) n = m_maxp;
          if (m_auto && n == 0) n = 1;
          send(n, ($urandom % 8) != 0);
        end else if (sel == 2) begin
          send(m_maxp + 1 + int'($urandom % 3), 1'b1);
        end else if (sel == 3) begin
          rd(1 + int'($urandom % 40));
        end else begin
          step(1'b0, 1'b1);
        end
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule